// File: doc/BRIEF.md
# IDE Host Address Decoder

This block sits between a host I/O port and the register files of a dual-channel disk controller. Each host request carries an address, a size (byte, half-word or word) and, for writes, data. The decoder compares the address against five windows whose base and size are inputs: a command window and a control window for each of the two channels, plus one bus-master window shared by both channels. From the first matching window it derives a block type, a channel and a window-relative offset. Command and control accesses are then forwarded to the drive port. Bus-master accesses are forwarded to the bus-master port.

Each channel has two drive positions. The decoder keeps a one-bit drive select per channel, snooped from byte writes to the drive/head select register, and uses it to form a two-bit drive index. A word access to the data register is broken into two half-word drive accesses. Read data from both halves is reassembled into the host response. Requests are taken one at a time: `req_ready` is high only while the decoder is idle, and every accepted request produces exactly one `rsp_valid` pulse.

Top module: `ide_host_decode`

## Requirements
- R1: A window matches when base <= address < base + size, computed with a carry bit so a window may end exactly at the top of the address space; the offset sent downstream is address minus base; window bases and sizes may change between requests.
- R2: The command windows give block type command (`drv_ctl` = 0) and the control windows give block type control (`drv_ctl` = 1); primary windows use channel 0 and secondary windows use channel 1.
- R3: In the bus-master window, offsets below `BM_SPLIT` (default 8) go to channel 0 and the rest to channel 1; the access appears once on the bus-master port with the host size and data, and its read data is returned unchanged.
- R4: A byte write to offset `SEL_OFF` (default 6) of a command window copies bit `SEL_BIT` (default 4) of the write data into that channel's drive select, and the same write is still forwarded to the drive.
- R5: The drive index is channel*2 + that channel's drive select, and that value already includes a select write made by the same request; both selects are 0 after reset.
- R6: A word (size code 2) access to offset `DATA_OFF` (default 0) of a command window becomes two drive accesses on consecutive cycles at the same offset and index: first bits 15:0 and then bits 31:16; on reads the first half fills rsp_rdata[15:0] and the second half fills rsp_rdata[31:16].
- R7: A half-word (size code 1) data-register access is a single drive access, with the read returned in rsp_rdata[15:0] and the upper bits zero.
- R8: Any other command or control register accepts only byte (size code 0) accesses; other sizes, and a byte access to the data register, respond with `rsp_err` = 1, read data of all ones, no drive access and no select change.
- R9: While `io_en` is low, an in-window request makes no downstream access and changes no select; it responds with `rsp_err` = 0 and read data of zero.
- R10: An address outside every window responds with `rsp_err` = 1 and read data of all ones, whatever the value of `io_en`.
- R11: `req_ready` is high only when idle; the response comes one cycle after acceptance for errors and disabled requests, and one cycle after the last downstream access otherwise; `rsp_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_en | input | 1 | I/O space enable |
| pcmd_base | input | ADDR_W | Primary command window base |
| pcmd_size | input | ADDR_W | Primary command window size |
| pctl_base | input | ADDR_W | Primary control window base |
| pctl_size | input | ADDR_W | Primary control window size |
| scmd_base | input | ADDR_W | Secondary command window base |
| scmd_size | input | ADDR_W | Secondary command window size |
| sctl_base | input | ADDR_W | Secondary control window base |
| sctl_size | input | ADDR_W | Secondary control window size |
| bmw_base | input | ADDR_W | Bus-master window base |
| bmw_size | input | ADDR_W | Bus-master window size |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Decoder idle, request taken |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request address |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data |
| drv_valid | output | 1 | Drive access this cycle |
| drv_write | output | 1 | Drive access is a write |
| drv_ctl | output | 1 | 0 command block, 1 control block |
| drv_index | output | 2 | Target drive 0..3 |
| drv_offset | output | OFF_W | Window-relative offset |
| drv_wdata | output | 16 | Drive write data |
| drv_rdata | input | 16 | Drive read data, same cycle |
| bm_valid | output | 1 | Bus-master access this cycle |
| bm_write | output | 1 | Bus-master access is a write |
| bm_chan | output | 1 | Channel of bus-master access |
| bm_offset | output | OFF_W | Offset in bus-master window |
| bm_size | output | 2 | Host size code |
| bm_wdata | output | 32 | Bus-master write data |
| bm_rdata | input | 32 | Bus-master read data, same cycle |

## Verification
The bench uses the default parameters: 16-bit addresses, 4-bit offsets, data register at 0, select register at 6 with the device bit at 4, and the bus-master split at 8. Because the windows are ports, the bench moves them between requests. One case places the bus-master window at 0xFFF0 with size 16, so its end lies exactly at 0x10000 and depends on the carry bit. Another moves the primary command window away from its usual address. A small drive model returns a different upper nibble on the second cycle of a split, so the order of the two halves can be seen in the reassembled word.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [1:0] {
        BLK_CMD  = 2'd0,
        BLK_CTL  = 2'd1,
        BLK_BM   = 2'd2,
        BLK_NONE = 2'd3
    } blk_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LO   = 3'd1,
        ST_HI   = 3'd2,
        ST_BM   = 3'd3,
        ST_RESP = 3'd4
    } st_e;

endpackage

// File: rtl/ide_win_cmp.sv
module ide_win_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    output logic              hit,
    output logic [ADDR_W-1:0] offs
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] lo_ext;
    logic [EXT_W-1:0] hi_ext;
    logic [EXT_W-1:0] a_ext;

    always_comb begin
        // one extra bit keeps a window ending at the top of the space exact
        lo_ext = {1'b0, base};
        hi_ext = {1'b0, base} + {1'b0, size};
        a_ext  = {1'b0, addr};
        hit    = (a_ext >= lo_ext) && (a_ext < hi_ext);
        offs   = addr - base;
    end

endmodule

// File: rtl/ide_win_pick.sv
module ide_win_pick
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int OFF_W    = 4,
    parameter int NWIN     = 5,
    parameter int BM_SPLIT = 8
) (
    input  logic [NWIN-1:0]             hit,
    input  logic [NWIN-1:0][ADDR_W-1:0] offs,
    output logic                        any,
    output blk_e                        blk,
    output logic                        chan,
    output logic [OFF_W-1:0]            off
);
    localparam int WIN_W = $clog2(NWIN);

    logic [WIN_W-1:0]  pick;
    logic [ADDR_W-1:0] full;

    // lowest-numbered window wins when windows overlap
    always_comb begin
        any  = 1'b0;
        pick = '0;
        full = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any  = 1'b1;
                pick = WIN_W'(i);
                full = offs[i];
            end
        end
    end

    always_comb begin
        off = full[OFF_W-1:0];
        case (pick)
            WIN_W'(0): begin blk = BLK_CMD; chan = 1'b0; end
            WIN_W'(1): begin blk = BLK_CTL; chan = 1'b0; end
            WIN_W'(2): begin blk = BLK_CMD; chan = 1'b1; end
            WIN_W'(3): begin blk = BLK_CTL; chan = 1'b1; end
            WIN_W'(4): begin
                blk  = BLK_BM;
                chan = (full < ADDR_W'(BM_SPLIT)) ? 1'b0 : 1'b1;
            end
            default: begin blk = BLK_NONE; chan = 1'b0; end
        endcase
        if (!any) begin
            blk  = BLK_NONE;
            chan = 1'b0;
        end
    end

endmodule

// File: rtl/ide_drv_sel.sv
module ide_drv_sel #(
    parameter int NCH = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd,
    input  logic [$clog2(NCH)-1:0] upd_chan,
    input  logic                   upd_bit,
    input  logic [$clog2(NCH)-1:0] q_chan,
    output logic [$clog2(NCH):0]   idx
);
    logic [NCH-1:0] sel_d;
    logic [NCH-1:0] sel_q;
    logic           sel_eff;

    always_comb begin
        sel_d = sel_q;
        if (upd) begin
            sel_d[upd_chan] = upd_bit;
        end
        // a select write counts for the access that carries it
        sel_eff = (upd && (upd_chan == q_chan)) ? upd_bit : sel_q[q_chan];
        idx     = {q_chan, sel_eff};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

endmodule

// File: rtl/ide_host_decode.sv
module ide_host_decode
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int OFF_W    = 4,
    parameter int DATA_OFF = 0,
    parameter int SEL_OFF  = 6,
    parameter int SEL_BIT  = 4,
    parameter int BM_SPLIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_en,
    input  logic [ADDR_W-1:0] pcmd_base,
    input  logic [ADDR_W-1:0] pcmd_size,
    input  logic [ADDR_W-1:0] pctl_base,
    input  logic [ADDR_W-1:0] pctl_size,
    input  logic [ADDR_W-1:0] scmd_base,
    input  logic [ADDR_W-1:0] scmd_size,
    input  logic [ADDR_W-1:0] sctl_base,
    input  logic [ADDR_W-1:0] sctl_size,
    input  logic [ADDR_W-1:0] bmw_base,
    input  logic [ADDR_W-1:0] bmw_size,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              drv_valid,
    output logic              drv_write,
    output logic              drv_ctl,
    output logic [1:0]        drv_index,
    output logic [OFF_W-1:0]  drv_offset,
    output logic [15:0]       drv_wdata,
    input  logic [15:0]       drv_rdata,
    output logic              bm_valid,
    output logic              bm_write,
    output logic              bm_chan,
    output logic [OFF_W-1:0]  bm_offset,
    output logic [1:0]        bm_size,
    output logic [31:0]       bm_wdata,
    input  logic [31:0]       bm_rdata
);
    localparam int NWIN = 5;
    localparam int NCH  = 2;

    typedef struct packed {
        st_e              st;
        logic             wr;
        logic [1:0]       sz;
        blk_e             blk;
        logic             chan;
        logic [1:0]       idx;
        logic [OFF_W-1:0] off;
        logic [31:0]      wd;
        logic [31:0]      rd;
        logic             err;
    } ctx_t;

    ctx_t ctx_d;
    ctx_t ctx_q;

    // window compare, one per window
    logic [NWIN-1:0][ADDR_W-1:0] w_base;
    logic [NWIN-1:0][ADDR_W-1:0] w_size;
    logic [NWIN-1:0][ADDR_W-1:0] w_offs;
    logic [NWIN-1:0]             w_hit;

    assign w_base = {bmw_base, sctl_base, scmd_base, pctl_base, pcmd_base};
    assign w_size = {bmw_size, sctl_size, scmd_size, pctl_size, pcmd_size};

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        ide_win_cmp #(
            .ADDR_W(ADDR_W)
        ) u_cmp (
            .addr (req_addr),
            .base (w_base[g]),
            .size (w_size[g]),
            .hit  (w_hit[g]),
            .offs (w_offs[g])
        );
    end

    logic             d_any;
    blk_e             d_blk;
    logic             d_chan;
    logic [OFF_W-1:0] d_off;

    ide_win_pick #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .NWIN     (NWIN),
        .BM_SPLIT (BM_SPLIT)
    ) u_pick (
        .hit  (w_hit),
        .offs (w_offs),
        .any  (d_any),
        .blk  (d_blk),
        .chan (d_chan),
        .off  (d_off)
    );

    // request classification
    logic take;
    logic is_data;
    logic size_ok;
    logic sel_upd;
    logic [1:0] d_idx;

    always_comb begin
        take    = (ctx_q.st == ST_IDLE) && req_valid;
        is_data = (d_blk == BLK_CMD) && (d_off == OFF_W'(DATA_OFF));
        if (is_data) begin
            size_ok = (req_size == SZ_HALF) || (req_size == SZ_WORD);
        end else begin
            size_ok = (req_size == SZ_BYTE);
        end
        sel_upd = take && d_any && io_en && req_write
                  && (d_blk == BLK_CMD) && (d_off == OFF_W'(SEL_OFF))
                  && (req_size == SZ_BYTE);
    end

    ide_drv_sel #(
        .NCH (NCH)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (sel_upd),
        .upd_chan (d_chan),
        .upd_bit  (req_wdata[SEL_BIT]),
        .q_chan   (d_chan),
        .idx      (d_idx)
    );

    // next-state
    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.wr   = req_write;
                    ctx_d.sz   = req_size;
                    ctx_d.blk  = d_blk;
                    ctx_d.chan = d_chan;
                    ctx_d.idx  = d_idx;
                    ctx_d.off  = d_off;
                    ctx_d.wd   = req_wdata;
                    ctx_d.rd   = '0;
                    ctx_d.err  = 1'b0;
                    if (!d_any) begin
                        ctx_d.err = 1'b1;
                        ctx_d.rd  = '1;
                        ctx_d.st  = ST_RESP;
                    end else if (!io_en) begin
                        ctx_d.st = ST_RESP;
                    end else if (d_blk == BLK_BM) begin
                        ctx_d.st = ST_BM;
                    end else if (!size_ok) begin
                        ctx_d.err = 1'b1;
                        ctx_d.rd  = '1;
                        ctx_d.st  = ST_RESP;
                    end else begin
                        ctx_d.st = ST_LO;
                    end
                end
            end
            ST_LO: begin
                if (ctx_q.sz == SZ_BYTE) begin
                    ctx_d.rd = {24'h0, drv_rdata[7:0]};
                end else begin
                    ctx_d.rd = {16'h0, drv_rdata};
                end
                ctx_d.st = (ctx_q.sz == SZ_WORD) ? ST_HI : ST_RESP;
            end
            ST_HI: begin
                ctx_d.rd[31:16] = drv_rdata;
                ctx_d.st        = ST_RESP;
            end
            ST_BM: begin
                ctx_d.rd = bm_rdata;
                ctx_d.st = ST_RESP;
            end
            ST_RESP: begin
                ctx_d.st = ST_IDLE;
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q     <= '0;
            ctx_q.st  <= ST_IDLE;
            ctx_q.blk <= BLK_NONE;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // outputs
    always_comb begin
        req_ready  = (ctx_q.st == ST_IDLE);
        rsp_valid  = (ctx_q.st == ST_RESP);
        rsp_err    = ctx_q.err;
        rsp_rdata  = ctx_q.rd;

        drv_valid  = (ctx_q.st == ST_LO) || (ctx_q.st == ST_HI);
        drv_write  = ctx_q.wr;
        drv_ctl    = (ctx_q.blk == BLK_CTL);
        drv_index  = ctx_q.idx;
        drv_offset = ctx_q.off;
        if (ctx_q.st == ST_HI) begin
            drv_wdata = ctx_q.wd[31:16];
        end else if (ctx_q.sz == SZ_BYTE) begin
            drv_wdata = {8'h00, ctx_q.wd[7:0]};
        end else begin
            drv_wdata = ctx_q.wd[15:0];
        end

        bm_valid   = (ctx_q.st == ST_BM);
        bm_write   = ctx_q.wr;
        bm_chan    = ctx_q.chan;
        bm_offset  = ctx_q.off;
        bm_size    = ctx_q.sz;
        bm_wdata   = ctx_q.wd;
    end

endmodule

// File: rtl/ide_host_decode_chk.sv
module ide_host_decode_chk #(
    parameter int OFF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_en,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [31:0]      rsp_rdata,
    input logic             drv_valid,
    input logic [1:0]       drv_index,
    input logic [OFF_W-1:0] drv_offset,
    input logic             bm_valid
);

    a_r10_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_rdata == 32'hFFFF_FFFF);

    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !drv_valid && !bm_valid && !rsp_valid);

    a_r6_split_same: assert property (@(posedge clk) disable iff (!rst_n)
        drv_valid && $past(drv_valid) |->
            drv_offset == $past(drv_offset) && drv_index == $past(drv_index));

    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !io_en |=> !drv_valid && !bm_valid);

    a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_valid && bm_valid));

endmodule

bind ide_host_decode ide_host_decode_chk #(
    .OFF_W (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_en      (io_en),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .drv_valid  (drv_valid),
    .drv_index  (drv_index),
    .drv_offset (drv_offset),
    .bm_valid   (bm_valid)
);

// File: tb/sim_ide_host_decode.sv
`timescale 1ns/1ps
module sim_ide_host_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_en = 1'b1;
    logic [15:0] pcmd_base = 16'h01F0, pcmd_size = 16'd8;
    logic [15:0] pctl_base = 16'h03F6, pctl_size = 16'd2;
    logic [15:0] scmd_base = 16'h0170, scmd_size = 16'd8;
    logic [15:0] sctl_base = 16'h0376, sctl_size = 16'd2;
    logic [15:0] bmw_base  = 16'hC000, bmw_size  = 16'd16;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        drv_valid, drv_write, drv_ctl;
    logic [1:0]  drv_index;
    logic [3:0]  drv_offset;
    logic [15:0] drv_wdata, drv_rdata;
    logic        bm_valid, bm_write, bm_chan;
    logic [3:0]  bm_offset;
    logic [1:0]  bm_size;
    logic [31:0] bm_wdata, bm_rdata;

    always #2.5 clk = ~clk;

    ide_host_decode u0 (
        .clk(clk), .rst_n(rst_n), .io_en(io_en),
        .pcmd_base(pcmd_base), .pcmd_size(pcmd_size),
        .pctl_base(pctl_base), .pctl_size(pctl_size),
        .scmd_base(scmd_base), .scmd_size(scmd_size),
        .sctl_base(sctl_base), .sctl_size(sctl_size),
        .bmw_base(bmw_base), .bmw_size(bmw_size),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .drv_valid(drv_valid), .drv_write(drv_write), .drv_ctl(drv_ctl),
        .drv_index(drv_index), .drv_offset(drv_offset),
        .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
        .bm_valid(bm_valid), .bm_write(bm_write), .bm_chan(bm_chan),
        .bm_offset(bm_offset), .bm_size(bm_size),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata)
    );

    // drive model: second cycle of back-to-back accesses returns nibble B
    logic ph = 1'b0;
    always @(posedge clk) ph <= drv_valid;
    assign drv_rdata = {(ph ? 4'hB : 4'hA), 2'b00, drv_index, 4'h0, drv_offset};
    assign bm_rdata  = {8'h5A, 7'h0, bm_chan, 12'h0, bm_offset};

    // access log
    int          n_drv = 0, n_bm = 0;
    logic [1:0]  l_idx [4];
    logic [3:0]  l_off [4];
    logic [15:0] l_wd  [4];
    logic        l_ctl [4];
    logic        l_wr  [4];
    logic        b_chan;
    logic [3:0]  b_off;
    logic [1:0]  b_size;
    always @(posedge clk) begin
        if (drv_valid && n_drv < 4) begin
            l_idx[n_drv] <= drv_index;
            l_off[n_drv] <= drv_offset;
            l_wd[n_drv]  <= drv_wdata;
            l_ctl[n_drv] <= drv_ctl;
            l_wr[n_drv]  <= drv_write;
            n_drv <= n_drv + 1;
        end
        if (bm_valid) begin
            b_chan <= bm_chan;
            b_off  <= bm_offset;
            b_size <= bm_size;
            n_bm   <= n_bm + 1;
        end
    end

    int n_chk = 0, n_err = 0;
    logic [31:0] r_data;
    logic        r_err;
    int          r_lat;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] wd);
        @(negedge clk);
        n_drv = 0; n_bm = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1;
        while (!rsp_valid && r_lat < 20) begin
            @(negedge clk);
            r_lat++;
        end
        r_data = rsp_rdata;
        r_err  = rsp_err;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 ready after reset", {31'h0, req_ready}, 32'd1);
        chk("R11 no response after reset", {31'h0, rsp_valid}, 32'd0);
        chk("R11 no drive access after reset", {31'h0, drv_valid}, 32'd0);
    endtask

    task automatic t_windows();
        acc(0, 16'h01F7, 2'd0, 0);
        chk("R1 pri cmd read data", r_data, 32'h0000_0007);
        chk("R1 pri cmd one access", n_drv, 1);
        chk("R1 offset", {28'h0, l_off[0]}, 32'd7);
        chk("R2 pri cmd block", {31'h0, l_ctl[0]}, 32'd0);
        chk("R5 pri index reset", {30'h0, l_idx[0]}, 32'd0);
        chk("R11 byte latency", r_lat, 2);
        acc(0, 16'h01F8, 2'd0, 0);
        chk("R1 past end error", {31'h0, r_err}, 32'd1);
        chk("R10 past end data", r_data, 32'hFFFF_FFFF);
        chk("R11 error latency", r_lat, 1);
        acc(0, 16'h03F6, 2'd0, 0);
        chk("R2 pri ctl block", {31'h0, l_ctl[0]}, 32'd1);
        chk("R2 pri ctl index", {30'h0, l_idx[0]}, 32'd0);
        acc(0, 16'h0177, 2'd0, 0);
        chk("R2 sec cmd block", {31'h0, l_ctl[0]}, 32'd0);
        chk("R5 sec index", {30'h0, l_idx[0]}, 32'd2);
        acc(0, 16'h0377, 2'd0, 0);
        chk("R2 sec ctl block", {31'h0, l_ctl[0]}, 32'd1);
        chk("R1 sec ctl offset", {28'h0, l_off[0]}, 32'd1);
    endtask

    task automatic t_bm();
        acc(0, 16'hC000, 2'd2, 0);
        chk("R3 bm low read", r_data, 32'h5A00_0000);
        chk("R3 bm size", {30'h0, b_size}, 32'd2);
        chk("R3 bm no drive", n_drv, 0);
        acc(0, 16'hC007, 2'd0, 0);
        chk("R3 bm off7 chan", {31'h0, b_chan}, 32'd0);
        acc(0, 16'hC008, 2'd2, 0);
        chk("R3 bm off8 read", r_data, 32'h5A01_0008);
        chk("R3 bm single access", n_bm, 1);
    endtask

    task automatic t_select();
        acc(1, 16'h01F6, 2'd0, 32'h10);
        chk("R4 select write forwarded", n_drv, 1);
        chk("R4 forwarded data", {16'h0, l_wd[0]}, 32'h0010);
        chk("R4 forwarded write", {31'h0, l_wr[0]}, 32'd1);
        chk("R5 same-request index", {30'h0, l_idx[0]}, 32'd1);
        acc(0, 16'h01F7, 2'd0, 0);
        chk("R5 pri drive 1", {30'h0, l_idx[0]}, 32'd1);
        acc(0, 16'h0177, 2'd0, 0);
        chk("R4 sec unaffected", {30'h0, l_idx[0]}, 32'd2);
        acc(1, 16'h01F6, 2'd0, 32'hEF);
        chk("R4 clear select", {30'h0, l_idx[0]}, 32'd0);
        acc(1, 16'h0176, 2'd0, 32'h10);
        acc(0, 16'h0376, 2'd0, 0);
        chk("R5 sec ctl drive 3", {30'h0, l_idx[0]}, 32'd3);
    endtask

    task automatic t_split();
        acc(1, 16'h01F0, 2'd2, 32'hDEAD_BEEF);
        chk("R6 two accesses", n_drv, 2);
        chk("R6 low half first", {16'h0, l_wd[0]}, 32'h0000_BEEF);
        chk("R6 high half second", {16'h0, l_wd[1]}, 32'h0000_DEAD);
        chk("R6 same offset", {28'h0, l_off[1]}, 32'd0);
        chk("R11 split latency", r_lat, 3);
        acc(0, 16'h0170, 2'd2, 0);
        chk("R6 read assembly", r_data, 32'hB300_A300);
        chk("R6 second index", {30'h0, l_idx[1]}, 32'd3);
    endtask

    task automatic t_half();
        acc(0, 16'h01F0, 2'd1, 0);
        chk("R7 half single access", n_drv, 1);
        chk("R7 half data", r_data, 32'h0000_A000);
    endtask

    task automatic t_size();
        acc(0, 16'h01F7, 2'd1, 0);
        chk("R8 half on status error", {31'h0, r_err}, 32'd1);
        chk("R8 error data", r_data, 32'hFFFF_FFFF);
        chk("R8 no drive access", n_drv, 0);
        acc(1, 16'h03F6, 2'd2, 32'h1234);
        chk("R8 word on ctl error", {31'h0, r_err}, 32'd1);
        acc(0, 16'h01F0, 2'd0, 0);
        chk("R8 byte on data error", {31'h0, r_err}, 32'd1);
        acc(1, 16'h01F6, 2'd1, 32'h10);
        acc(0, 16'h01F7, 2'd0, 0);
        chk("R8 bad-size select ignored", {30'h0, l_idx[0]}, 32'd0);
    endtask

    task automatic t_disabled();
        io_en = 1'b0;
        acc(1, 16'h01F6, 2'd0, 32'h10);
        chk("R9 disabled no access", n_drv, 0);
        chk("R9 disabled no error", {31'h0, r_err}, 32'd0);
        acc(0, 16'h01F7, 2'd0, 0);
        chk("R9 disabled read zero", r_data, 32'h0);
        acc(0, 16'h0100, 2'd0, 0);
        chk("R10 miss while disabled", {31'h0, r_err}, 32'd1);
        chk("R10 miss data", r_data, 32'hFFFF_FFFF);
        io_en = 1'b1;
        acc(0, 16'h01F7, 2'd0, 0);
        chk("R9 select unchanged", {30'h0, l_idx[0]}, 32'd0);
    endtask

    task automatic t_move();
        bmw_base = 16'hFFF0;
        pcmd_base = 16'h0100;
        acc(0, 16'hFFFF, 2'd2, 0);
        chk("R1 window at top of space", r_data, 32'h5A01_000F);
        acc(0, 16'h01F7, 2'd0, 0);
        chk("R1 old base now miss", {31'h0, r_err}, 32'd1);
        acc(0, 16'h0107, 2'd0, 0);
        chk("R1 new base hit", {28'h0, l_off[0]}, 32'd7);
        chk("R1 new base no error", {31'h0, r_err}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_windows();
        t_bm();
        t_select();
        t_split();
        t_half();
        t_size();
        t_disabled();
        t_move();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule